// File: doc/BRIEF.md
# Serial E3 Frame-Master Payload Input

This block is the transmit-side payload entry point of an E3 framer that runs from a single local bit clock and sets its own frame boundaries. A free-running position counter divides time into outbound frames of `FRAME_BITS` bit periods. No external frame signal influences it. In every bit period the block takes one bit from a serial data pin.

In the bit period that carries the final position of each frame, the block raises a one-clock end-of-frame strobe. The attached terminal equipment watches this strobe and presents the first bit of the following frame in the next period. The first `OH_BITS` positions of each frame are reserved for overhead. During those positions an indicator output is high and the serial input is not taken.

Each accepted payload bit goes to downstream logic one clock later, together with a valid pulse and the frame position it was sampled at. A start-of-frame flag marks position 0.

Top module: `e3fm_payload_in`

## Requirements
- R1: While `rst_i` is high (sampled at a rising edge), `frame_end_o`, `oh_ind_o` and `sof_o` are low. `pld_val_o` is low in the cycle after any reset edge. After release, the frame restarts at position 0.
- R2: The position counter advances by one on every rising edge that has `rst_i` low. It runs from 0 to `FRAME_BITS-1` and wraps to 0, whatever `data_i` carries.
- R3: `frame_end_o` is high for exactly one clock, during position `FRAME_BITS-1`. It first rises in the `FRAME_BITS`-th bit period after reset release and then recurs every `FRAME_BITS` clocks.
- R4: `sof_o` is high exactly while the counter is at position 0, which is the period right after each strobe.
- R5: `oh_ind_o` is high exactly during positions 0 to `OH_BITS-1`, which is 12 consecutive clocks per frame by default.
- R6: At the rising edge that ends a payload position (`OH_BITS` to `FRAME_BITS-1`), `data_i` is latched. In the next cycle `pld_val_o` is 1 and `pld_bit_o` equals the latched level.
- R7: `pld_idx_o` gives the frame position of the bit on `pld_bit_o`. Consecutive valid outputs carry consecutive ascending positions.
- R8: `data_i` is ignored during overhead positions. `pld_val_o` stays 0 in the cycle after each overhead position, whatever level `data_i` held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local bit clock; all timing derives from it |
| rst_i | input | 1 | Synchronous active-high reset |
| data_i | input | 1 | Serial payload from terminal equipment |
| frame_end_o | output | 1 | High during the last bit position of a frame |
| oh_ind_o | output | 1 | High during overhead positions |
| sof_o | output | 1 | High during position 0 |
| pld_val_o | output | 1 | Captured payload bit valid |
| pld_bit_o | output | 1 | Captured payload bit |
| pld_idx_o | output | clog2(FRAME_BITS) (11) | Frame position of the captured bit |

## Verification
The assertions assume that `rst_i` is high from the first clock edge, so the checker's own frame-gap counter starts in step with the design. They also assume `data_i` is a defined 0 or 1 that is stable across each rising edge, because the capture property compares the output against the value sampled there. The stimulus keeps within these assumptions. It holds reset from time zero, changes `data_i` and `rst_i` only at falling edges, and always drives a known level. Mid-frame resets are applied only at falling edges, so every reset is seen whole by the checker.

// File: rtl/e3fm_pkg.sv
package e3fm_pkg;

   // Frame markers decoded from the bit position
   typedef struct packed {
      logic sof;
      logic oh;
      logic last;
   } e3fm_marks_t;

   function automatic int unsigned pos_width(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/e3fm_pos_ctr.sv
module e3fm_pos_ctr #(
   parameter int unsigned FRAME_BITS = 1536,
   parameter int unsigned POS_W      = 11
) (
   input  logic             clk_i,
   input  logic             rst_i,
   output logic [POS_W-1:0] pos_o
);

   localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);
   localparam bit               POW2     = (FRAME_BITS == (1 << POS_W));

   logic [POS_W-1:0] pos_nxt;

   generate
      if (POW2) begin : g_natural_wrap
         assign pos_nxt = pos_o + POS_W'(1);
      end else begin : g_compare_wrap
         assign pos_nxt = (pos_o == LAST_POS) ? '0 : pos_o + POS_W'(1);
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i) pos_o <= '0;
      else       pos_o <= pos_nxt;
   end

endmodule

// File: rtl/e3fm_marks.sv
module e3fm_marks #(
   parameter int unsigned FRAME_BITS = 1536,
   parameter int unsigned OH_BITS    = 12,
   parameter int unsigned POS_W      = 11
) (
   input  logic                   rst_i,
   input  logic [POS_W-1:0]       pos_i,
   output e3fm_pkg::e3fm_marks_t  marks_o
);

   localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

   logic in_oh;

   generate
      if (OH_BITS == 0) begin : g_no_oh
         assign in_oh = 1'b0;
      end else begin : g_oh
         assign in_oh = (pos_i < POS_W'(OH_BITS));
      end
   endgenerate

   always_comb begin
      marks_o.sof  = !rst_i && (pos_i == '0);
      marks_o.oh   = !rst_i && in_oh;
      marks_o.last = !rst_i && (pos_i == LAST_POS);
   end

endmodule

// File: rtl/e3fm_sampler.sv
module e3fm_sampler #(
   parameter int unsigned POS_W = 11
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             take_i,
   input  logic             data_i,
   input  logic [POS_W-1:0] pos_i,
   output logic             val_o,
   output logic             bit_o,
   output logic [POS_W-1:0] idx_o
);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         val_o <= 1'b0;
         bit_o <= 1'b0;
         idx_o <= '0;
      end else begin
         val_o <= take_i;
         if (take_i) begin
            bit_o <= data_i;
            idx_o <= pos_i;
         end
      end
   end

endmodule

// File: rtl/e3fm_payload_in.sv
module e3fm_payload_in #(
   parameter int unsigned FRAME_BITS = 1536,
   parameter int unsigned OH_BITS    = 12,
   localparam int unsigned POS_W     = e3fm_pkg::pos_width(FRAME_BITS)
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             data_i,
   output logic             frame_end_o,
   output logic             oh_ind_o,
   output logic             sof_o,
   output logic             pld_val_o,
   output logic             pld_bit_o,
   output logic [POS_W-1:0] pld_idx_o
);

   generate
      if (FRAME_BITS < 2) begin : g_bad_frame
         $error("FRAME_BITS must be at least 2");
      end
      if (OH_BITS >= FRAME_BITS) begin : g_bad_oh
         $error("OH_BITS must leave at least one payload position");
      end
   endgenerate

   logic [POS_W-1:0]      pos;
   e3fm_pkg::e3fm_marks_t marks;
   logic                  take;

   e3fm_pos_ctr #(
      .FRAME_BITS (FRAME_BITS),
      .POS_W      (POS_W)
   ) u_pos (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .pos_o (pos)
   );

   e3fm_marks #(
      .FRAME_BITS (FRAME_BITS),
      .OH_BITS    (OH_BITS),
      .POS_W      (POS_W)
   ) u_marks (
      .rst_i   (rst_i),
      .pos_i   (pos),
      .marks_o (marks)
   );

   assign take = !rst_i && !marks.oh;

   e3fm_sampler #(
      .POS_W (POS_W)
   ) u_samp (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .take_i (take),
      .data_i (data_i),
      .pos_i  (pos),
      .val_o  (pld_val_o),
      .bit_o  (pld_bit_o),
      .idx_o  (pld_idx_o)
   );

   assign frame_end_o = marks.last;
   assign oh_ind_o    = marks.oh;
   assign sof_o       = marks.sof;

endmodule

// File: rtl/e3fm_payload_in_chk.sv
module e3fm_payload_in_chk #(
   parameter int unsigned FRAME_BITS = 1536,
   parameter int unsigned OH_BITS    = 12,
   parameter int unsigned POS_W      = 11
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic             data_i,
   input logic             frame_end_o,
   input logic             oh_ind_o,
   input logic             sof_o,
   input logic             pld_val_o,
   input logic             pld_bit_o,
   input logic [POS_W-1:0] pld_idx_o
);

   localparam logic [POS_W-1:0] GAP_LAST = POS_W'(FRAME_BITS - 1);

   logic [POS_W-1:0] gap;

   always_ff @(posedge clk_i) begin
      if (rst_i)                gap <= '0;
      else if (gap == GAP_LAST) gap <= '0;
      else                      gap <= gap + POS_W'(1);
   end

   // R1
   rst_quiet_chk: assert property (@(posedge clk_i)
      rst_i |-> (!frame_end_o && !oh_ind_o && !sof_o));

   // R1
   rst_clears_val_chk: assert property (@(posedge clk_i)
      rst_i |=> !pld_val_o);

   // R3
   strobe_place_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (gap == GAP_LAST) |-> frame_end_o);

   // R3
   strobe_width_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      frame_end_o |=> !frame_end_o);

   // R4
   sof_after_strobe_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      frame_end_o |=> sof_o);

   // R2
   sof_place_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      sof_o |-> (gap == '0));

   // R8
   no_take_in_oh_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      oh_ind_o |=> !pld_val_o);

   // R6
   capture_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !oh_ind_o |=> (pld_val_o && (pld_bit_o == $past(data_i))));

   // R7
   idx_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (pld_val_o && $past(pld_val_o)) |-> (pld_idx_o == $past(pld_idx_o) + POS_W'(1)));

endmodule

bind e3fm_payload_in e3fm_payload_in_chk #(
   .FRAME_BITS (FRAME_BITS),
   .OH_BITS    (OH_BITS),
   .POS_W      (POS_W)
) u_chk (
   .clk_i       (clk_i),
   .rst_i       (rst_i),
   .data_i      (data_i),
   .frame_end_o (frame_end_o),
   .oh_ind_o    (oh_ind_o),
   .sof_o       (sof_o),
   .pld_val_o   (pld_val_o),
   .pld_bit_o   (pld_bit_o),
   .pld_idx_o   (pld_idx_o)
);

// File: tb/e3fm_payload_in_test.sv
`timescale 1ns/1ps
module e3fm_payload_in_test;

   localparam int FB = 1536;
   localparam int OH = 12;
   localparam int PW = 11;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          din = 1'b0;
   logic          frame_end, oh_ind, sof, pld_val, pld_bit;
   logic [PW-1:0] pld_idx;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // bench model state
   int epos, cyc, last_strobe, src_pos, src_frame;
   bit prev_take, prev_data, prev_strobe;
   int prev_pos;

   always #4 clk = ~clk;

   e3fm_payload_in uut (
      .clk_i       (clk),
      .rst_i       (rst),
      .data_i      (din),
      .frame_end_o (frame_end),
      .oh_ind_o    (oh_ind),
      .sof_o       (sof),
      .pld_val_o   (pld_val),
      .pld_bit_o   (pld_bit),
      .pld_idx_o   (pld_idx)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic bit pat(input int frame, input int pos);
      case (frame % 4)
         0: return bit'(pos & 1);
         1: return ((pos * 7 + frame * 3) % 5) < 2;
         2: return 1'b1;
         default: return bit'(((pos >> 2) ^ pos ^ (pos >> 5)) & 1);
      endcase
   endfunction

   task automatic report;
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic apply_reset(input int n);
      @(negedge clk);
      rst = 1'b1;
      din = 1'b1;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         #1;
         // R1: markers and valid quiet under reset
         chk(!frame_end, "R1", "frame_end in reset", int'(frame_end), 0);
         chk(!oh_ind,    "R1", "oh_ind in reset",    int'(oh_ind),    0);
         chk(!sof,       "R1", "sof in reset",       int'(sof),       0);
         chk(!pld_val,   "R1", "pld_val in reset",   int'(pld_val),   0);
      end
      rst = 1'b0;
      epos = 0; cyc = 0; last_strobe = -1;
      src_pos = 0; src_frame = 0;
      prev_take = 1'b0; prev_data = 1'b0; prev_pos = 0; prev_strobe = 1'b0;
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) begin
         bit d;
         #1;
         // R2 / R3: strobe only at last position
         chk(frame_end == (epos == FB - 1), "R3", "frame_end vs position",
             int'(frame_end), int'(epos == FB - 1));
         // R4
         chk(sof == (epos == 0), "R4", "sof vs position", int'(sof), int'(epos == 0));
         // R5
         chk(oh_ind == (epos < OH), "R5", "oh_ind vs position", int'(oh_ind), int'(epos < OH));
         // R6 / R8: valid follows payload positions only
         chk(pld_val == prev_take, prev_take ? "R6" : "R8", "pld_val",
             int'(pld_val), int'(prev_take));
         if (prev_take) begin
            chk(pld_bit == prev_data, "R6", "captured bit", int'(pld_bit), int'(prev_data));
            chk(int'(pld_idx) == prev_pos, "R7", "captured index", int'(pld_idx), prev_pos);
         end
         if (frame_end) begin
            // R3: width, first occurrence, period
            chk(!prev_strobe, "R3", "strobe width", int'(prev_strobe), 0);
            if (last_strobe < 0)
               chk(cyc == FB - 1, "R3", "first strobe cycle", cyc, FB - 1);
            else
               chk(cyc - last_strobe == FB, "R3", "strobe period", cyc - last_strobe, FB);
            last_strobe = cyc;
         end
         // model source: aligned to the strobe, payload pattern per frame
         d = (src_pos < OH) ? bit'(src_frame & 1) : pat(src_frame, src_pos);
         din = d;
         prev_take = (epos >= OH);
         prev_data = d;
         prev_pos  = epos;
         prev_strobe = frame_end;
         if (frame_end) begin
            src_pos = 0;
            src_frame++;
         end else begin
            src_pos++;
         end
         epos = (epos + 1) % FB;
         cyc++;
         @(negedge clk);
      end
   endtask

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      report();
   end

   initial begin
      apply_reset(3);
      run(4 * FB + 40);
      // R1: mid-frame reset restarts the frame at position 0
      apply_reset(2);
      run(2 * FB + 20);
      report();
   end

endmodule